// File: doc/BRIEF.md
# Second-Order Single-Bit Delta-Sigma Modulator

This block is a digital model of a second-order delta-sigma modulator. Every rising edge of the master clock it takes a signed 16-bit sample and produces one output bit. Over a long window, the fraction of ones in that stream tracks the input linearly. A zero input gives half ones. Positive full scale gives almost all ones, and negative full scale gives almost all zeros. A downstream decimation filter, which is not part of this block, rebuilds a multi-bit word from the stream.

The loop has two cascaded accumulators followed by a sign quantizer. The previous output bit selects a feedback value of plus or minus full scale, and that value is subtracted at the input of both accumulators. The accumulators are wider than the input and saturate instead of wrapping. Samples below the rated negative limit are clamped to it first. The only clock is the master clock, and reset is synchronous and active high.

Top module: `dsm2_modulator`

## Requirements
- R1: While `rst` is high at a rising edge, both accumulators are cleared and `bit_o` becomes 0. The first modulated bit appears after the first rising edge with `rst` low; for a zero input that bit is 1.
- R2: Let c be the clamped sample and let fb be +32768 when `bit_o` is 1 and −32768 when it is 0. At each edge the first accumulator becomes A1' = A1 + c − fb. The second becomes A2' = A2 + A1' − fb. `bit_o` becomes 1 exactly when A2' ≥ 0. This gives one bit per clock.
- R3: Each accumulator result is limited to the signed range of `ACC_W` bits, so it saturates at the largest positive or most negative value and never wraps.
- R4: A sample below −32767 (that is, −32768) is treated as −32767. Samples in [−32767, 32767] pass unchanged.
- R5: A constant input of 0 gives 50 % ones, within 0.1 % over a 32768-clock window.
- R6: A constant input of +20480 (200/320 of full scale) gives 81.25 % ones, within 0.1 %.
- R7: A constant input of −20480 gives 18.75 % ones, within 0.1 %.
- R8: A constant input of +32767 gives a ones density of 0.5 + 32767/65536 (about 100 %), within 0.1 %.
- R9: A constant input of −32768 gives the density of the clamped value −32767 (about 0 %), within 0.1 % over a 16384-clock window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | IN_W (16) | Signed two's-complement input sample |
| bit_o | output | 1 | Registered one-bit modulator output |

## Verification
The assertions check four things on every cycle. Reset clears the accumulators and the output bit. The output bit always agrees with the sign of the second accumulator it was decided from. An accumulator never moves backwards across its range when its increment points the other way, which would be a wrap. Samples inside the rated span pass through the clamp untouched.

Whether the recurrence uses the right feedback magnitude, the right ordering between the two stages and the right clamp value can only be shown by the bench's scenarios. The bench compares the bit stream against an arithmetic model under constant inputs and a sweep across the whole input range. It runs a narrow-accumulator instance that is driven into saturation. It also counts ones over long windows at the rated DC points.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;
  // default sizes of the modulator
  localparam int DSM_IN_W_DEF  = 16;
  localparam int DSM_ACC_W_DEF = 32;

  // feedback polarity chosen by the previous output bit
  typedef enum logic {
    FB_NEG = 1'b0,
    FB_POS = 1'b1
  } fb_sel_e;
endpackage

// File: rtl/dsm2_clamp.sv
module dsm2_clamp #(
  parameter int IN_W  = 16,
  parameter int LIMIT = 32767
) (
  input  logic signed [IN_W-1:0] raw_i,
  output logic signed [IN_W-1:0] lim_o
);
  localparam logic signed [IN_W-1:0] HI = IN_W'(LIMIT);
  localparam logic signed [IN_W-1:0] LO = -HI;

  always_comb begin
    if (raw_i > HI)      lim_o = HI;
    else if (raw_i < LO) lim_o = LO;
    else                 lim_o = raw_i;
  end
endmodule

// File: rtl/dsm2_integ.sv
module dsm2_integ #(
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] src_i,
  input  logic signed [ACC_W-1:0] fb_i,
  output logic signed [ACC_W-1:0] nxt_o,
  output logic signed [ACC_W-1:0] q_o
);
  localparam int EW = ACC_W + 2;
  localparam logic signed [EW-1:0] MAXV = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [EW-1:0] MINV = {3'b111, {(ACC_W-1){1'b0}}};

  logic signed [EW-1:0] delta;
  logic signed [EW-1:0] sum;

  // widened arithmetic so that no intermediate result can wrap
  assign delta = $signed({{2{src_i[ACC_W-1]}}, src_i}) - $signed({{2{fb_i[ACC_W-1]}}, fb_i});
  assign sum   = $signed({{2{q_o[ACC_W-1]}}, q_o}) + delta;

  always_comb begin
    if (sum > MAXV)      nxt_o = MAXV[ACC_W-1:0];
    else if (sum < MINV) nxt_o = MINV[ACC_W-1:0];
    else                 nxt_o = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= nxt_o;
  end

  // R1
  int_clr_chk: assert property (@(posedge clk) rst |=> q_o == '0);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (q_o >= 0 && delta > 0) |=> q_o >= $past(q_o));

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (q_o < 0 && delta < 0) |=> q_o <= $past(q_o));
endmodule

// File: rtl/dsm2_quant.sv
module dsm2_quant #(
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] level_i,
  output logic                    bit_o
);
  always_ff @(posedge clk) begin
    if (rst) bit_o <= 1'b0;
    else     bit_o <= ~level_i[ACC_W-1];
  end

  // R1
  bit_clr_chk: assert property (@(posedge clk) rst |=> !bit_o);
endmodule

// File: rtl/dsm2_modulator.sv
module dsm2_modulator
  import dsm2_pkg::*;
#(
  parameter int IN_W     = DSM_IN_W_DEF,
  parameter int ACC_W    = DSM_ACC_W_DEF,
  parameter int IN_LIMIT = (2 ** (IN_W - 1)) - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic signed [IN_W-1:0] sample_i,
  output logic                   bit_o
);
  localparam int NSTAGE = 2;
  localparam logic signed [ACC_W-1:0] FS_POS = ACC_W'(2 ** (IN_W - 1));
  localparam logic signed [ACC_W-1:0] FS_NEG = -FS_POS;

  logic signed [IN_W-1:0]  x_lim;
  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W-1:0] fb;
  fb_sel_e                 fb_sel;
  logic signed [ACC_W-1:0] stg_nxt [NSTAGE];
  logic signed [ACC_W-1:0] stg_q   [NSTAGE];

  dsm2_clamp #(.IN_W(IN_W), .LIMIT(IN_LIMIT)) u_clamp (
    .raw_i (sample_i),
    .lim_o (x_lim)
  );

  assign x_ext  = {{(ACC_W-IN_W){x_lim[IN_W-1]}}, x_lim};
  assign fb_sel = fb_sel_e'(bit_o);
  assign fb     = (fb_sel == FB_POS) ? FS_POS : FS_NEG;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    logic signed [ACC_W-1:0] src;
    if (k == 0) begin : g_first
      assign src = x_ext;
    end else begin : g_chain
      assign src = stg_nxt[k-1];
    end
    dsm2_integ #(.ACC_W(ACC_W)) u_integ (
      .clk   (clk),
      .rst   (rst),
      .src_i (src),
      .fb_i  (fb),
      .nxt_o (stg_nxt[k]),
      .q_o   (stg_q[k])
    );
  end

  dsm2_quant #(.ACC_W(ACC_W)) u_quant (
    .clk     (clk),
    .rst     (rst),
    .level_i (stg_nxt[NSTAGE-1]),
    .bit_o   (bit_o)
  );

  // R2
  quant_sign_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> bit_o == (stg_q[NSTAGE-1] >= 0));

  // R4
  in_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_i >= -IN_LIMIT && sample_i <= IN_LIMIT) |-> x_lim == sample_i);
endmodule

// File: tb/tb_dsm2_modulator.sv
module tb_dsm2_modulator;
  logic clk = 1'b0;
  logic rst_drv;
  logic signed [15:0] x_drv;
  logic bit_w, bit_s;

  always #4 clk = ~clk;

  dsm2_modulator dut (
    .clk(clk), .rst(rst_drv), .sample_i(x_drv), .bit_o(bit_w)
  );

  dsm2_modulator #(.ACC_W(18)) dut_s (
    .clk(clk), .rst(rst_drv), .sample_i(x_drv), .bit_o(bit_s)
  );

  longint m1 [2];
  longint m2 [2];
  logic   mb [2];
  longint hi [2];
  int     mism [2];
  longint fa [2];
  longint fe [2];
  int     pass_n = 0;
  int     tot_n  = 0;
  int     ones;
  bit     done = 1'b0;

  function automatic longint sat(input longint v, input longint h);
    if (v > h) return h;
    if (v < -h - 1) return -h - 1;
    return v;
  endfunction

  function automatic longint clampx(input longint x);
    return (x < -32767) ? -32767 : x;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tot_n++;
    if (ok) pass_n++;
    else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  task automatic model_step(input longint x, input bit r);
    for (int k = 0; k < 2; k++) begin
      if (r) begin
        m1[k] = 0; m2[k] = 0; mb[k] = 1'b0;
      end else begin
        longint fbv;
        fbv   = mb[k] ? 32768 : -32768;
        m1[k] = sat(m1[k] + clampx(x) - fbv, hi[k]);
        m2[k] = sat(m2[k] + m1[k] - fbv, hi[k]);
        mb[k] = (m2[k] >= 0);
      end
    end
  endtask

  task automatic step(input logic signed [15:0] x, input bit r);
    logic act [2];
    x_drv   = x;
    rst_drv = r;
    @(negedge clk);
    model_step(longint'(x), r);
    act[0] = bit_w;
    act[1] = bit_s;
    for (int k = 0; k < 2; k++) begin
      if (act[k] !== mb[k]) begin
        if (mism[k] == 0) begin
          fa[k] = longint'(act[k]);
          fe[k] = longint'(mb[k]);
        end
        mism[k]++;
      end
    end
    if (!r && bit_w) ones++;
  endtask

  task automatic do_reset(input logic signed [15:0] x);
    step(x, 1'b1);
    step(x, 1'b1);
    // R1: output cleared by reset on both instances
    chk(bit_w == 1'b0 && bit_s == 1'b0, "R1 output after reset", longint'({bit_w, bit_s}), 0);
    mism[0] = 0; mism[1] = 0;
    ones = 0;
  endtask

  task automatic run_dc(input logic signed [15:0] x, input int n, input string dtag, input string mtag);
    longint err, xc;
    do_reset(x);
    for (int i = 0; i < n; i++) begin
      step(x, 1'b0);
      if (i == 0 && x == 0) chk(bit_w == 1'b1, "R1 first bit after release", longint'(bit_w), 1);
    end
    xc  = clampx(longint'(x));
    err = longint'(ones) * 65536 - longint'(n) * (xc + 32768);
    if (err < 0) err = -err;
    chk(err * 1000 <= longint'(n) * 65536, dtag, longint'(ones), (longint'(n) * (xc + 32768)) / 65536);
    chk(mism[0] == 0, mtag, fa[0], fe[0]);
    chk(mism[1] == 0, "R3 narrow accumulator stream", fa[1], fe[1]);
  endtask

  initial begin
    hi[0] = 64'sd2147483647;
    hi[1] = 64'sd131071;
    mism[0] = 0; mism[1] = 0;
    x_drv = '0;
    rst_drv = 1'b1;

    run_dc(16'sd0,      32768, "R5 zero input density",     "R2 stream at zero");
    run_dc(16'sd20480,  32768, "R6 +20480 density",         "R2 stream at +20480");
    run_dc(-16'sd20480, 32768, "R7 -20480 density",         "R2 stream at -20480");
    run_dc(16'sd32767,  32768, "R8 +32767 density",         "R2 stream at +32767");
    run_dc(-16'sd32768, 16384, "R9 -32768 density",         "R4 clamp of -32768 stream");

    // R2 / R3: sweep across the whole input range without reset
    do_reset(16'sd0);
    for (int v = -32768; v <= 32767; v += 509) begin
      for (int j = 0; j < 6; j++) step(16'(v), 1'b0);
    end
    chk(mism[0] == 0, "R2 sweep stream", fa[0], fe[0]);
    chk(mism[1] == 0, "R3 sweep narrow stream", fa[1], fe[1]);

    done = 1'b1;
    $display("%0d/%0d checks passed", pass_n, tot_n);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tot_n++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", pass_n, tot_n);
      $finish;
    end
  end
endmodule